// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block sits at the front of a small 8-bit accumulator processor. It reads instruction bytes one at a time through a byte-wide memory read port. Each instruction is an opcode byte, followed in memory by zero, one or two operand bytes. The sequencer classifies the opcode as soon as it arrives, collects the operand bytes that class needs, and assembles two-byte operands with the high byte first. Stack-relative forms need one more read, at the stack pointer plus an 8-bit offset. The finished instruction goes out as one record. The record carries the opcode, its operand class, the assembled immediate, the fetched data byte and its address, and the number of clocks the instruction occupies.

The memory read port uses a valid/ready handshake. The block raises `mem_rd_valid` with an address. A read completes in a cycle where `mem_ready` is also high, and `mem_rdata` must hold the byte during that cycle. While `mem_ready` is low, the request stays in place unchanged. The instruction output is also valid/ready. A record stays on the port until the consumer takes it. While the record is held, no further memory read is issued, so back-pressure from the consumer stalls fetching. Opcode 00 sends the fetch address back to zero and gives a one-cycle pulse, which the register file uses to clear itself, including the interrupt-enable flag. Opcodes that have no assigned function give a one-cycle pulse of their own and otherwise behave as 1-clock no-operations.

Top module: `fetch_seq`

## Requirements
- R1: During and directly after reset, `ins_valid` is 0, `mem_rd_valid` is 1 and `mem_addr` is 0.
- R2: The read address advances by one for each opcode or operand byte consumed. The next opcode is read at the address after the last operand byte.
- R3: `ins_kind` follows this lookup, with codes 0 = no operand, 1 = one-byte immediate, 2 = two-byte immediate, 3 = stack-relative, 4 = clear, 5 = unassigned. Code 4 is opcode 00. Code 5 is 02–05, 70, 77, 79, 99, 9A, A6, AD and B4. Code 2 is 06, 07, 68–6F, 7A–7F, 92–95, CC–CF and EC–EF. Code 1 is 24, 71–76, 78 and D0–D4. Code 3 is the rest of B0–BF, plus D5–D9. Every other opcode is code 0.
- R4: For code 2, the first operand byte becomes `ins_imm[15:8]` and the second becomes `ins_imm[7:0]`.
- R5: For codes 1 and 3, `ins_imm` is the operand byte zero-extended. For codes 0, 4 and 5, `ins_imm` is 0.
- R6: For code 3, a third read is made at `stack_ptr` plus the zero-extended offset, modulo 2^ADDR_W. `stack_ptr` is sampled in the cycle the offset is read. That address is reported on `ins_daddr` and the byte read there on `ins_data`. For other codes, both fields are 0.
- R7: Opcode 00 takes 1 clock. Its record comes with a single-cycle `clear_pulse`, and the next opcode is read at address 0.
- R8: An unassigned opcode takes 1 clock. Its record comes with a single-cycle `illegal_pulse`. The two pulses are never high together.
- R9: While `mem_rd_valid` is high and `mem_ready` is low, the request and its address are held into the next cycle.
- R10: While `ins_valid` is high and `ins_ready` is low, the record is held unchanged and `mem_rd_valid` is 0.
- R11: `ins_cycles` is 1 for codes 0, 4 and 5, 2 for code 1, and 3 for codes 2 and 3. With both ready inputs held high, consecutive records are accepted exactly that many cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rd_valid | output | 1 | Read request valid |
| mem_ready | input | 1 | Memory accepts the read and returns data this cycle |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rdata | input | 8 | Read data, valid when the read completes |
| stack_ptr | input | ADDR_W | Current stack pointer from the register file |
| ins_valid | output | 1 | Instruction record valid |
| ins_ready | input | 1 | Consumer takes the record |
| ins_opcode | output | 8 | Opcode byte |
| ins_kind | output | 3 | Operand class code (R3) |
| ins_imm | output | 16 | Assembled immediate |
| ins_cycles | output | 2 | Clock count of the instruction |
| ins_daddr | output | ADDR_W | Stack-relative data address |
| ins_data | output | 8 | Byte read from the stack-relative address |
| illegal_pulse | output | 1 | One-cycle flag for an unassigned opcode |
| clear_pulse | output | 1 | One-cycle flag for the clear instruction |

## Verification
A wrong class lookup shows up first at the memory port. The read after an opcode lands on the wrong address, or the next opcode is read too early or too late, within one or two cycles of the faulty opcode. The wrong `ins_kind` and `ins_cycles` then appear in the record one cycle after the last read. A corrupted operand shift shows up as swapped or stale bytes in `ins_imm` in the record that follows. A wrong offset sum shows up as a bad third read address in the same instruction. The bench rebuilds every expected address and record from the program it writes, first with both ready inputs high and then under random stalls on both sides. This way, hold and ordering faults show up as soon as one side stalls.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int BYTE_W = 8;
  localparam int CYC_W  = 2;
  localparam int TAIL_W = 2;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_IMM8  = 3'd1,
    K_IMM16 = 3'd2,
    K_STK   = 3'd3,
    K_RST   = 3'd4,
    K_ILL   = 3'd5
  } opk_e;

  function automatic opk_e opk_of(input logic [BYTE_W-1:0] op);
    opk_e k;
    k = K_NONE;
    if (op == 8'h00)
      k = K_RST;
    else if (op inside {[8'h02:8'h05], 8'h70, 8'h77, 8'h79, 8'h99, 8'h9A,
                        8'hA6, 8'hAD, 8'hB4})
      k = K_ILL;
    else if (op inside {8'h06, 8'h07, [8'h68:8'h6F], [8'h7A:8'h7F],
                        [8'h92:8'h95], [8'hCC:8'hCF], [8'hEC:8'hEF]})
      k = K_IMM16;
    else if (op inside {8'h24, [8'h71:8'h76], 8'h78, [8'hD0:8'hD4]})
      k = K_IMM8;
    else if (op inside {[8'hB0:8'hBF], [8'hD5:8'hD9]})
      k = K_STK;
    return k;
  endfunction

  function automatic logic [CYC_W-1:0] cyc_of(input opk_e k);
    logic [CYC_W-1:0] c;
    case (k)
      K_IMM8:         c = 2'd2;
      K_IMM16, K_STK: c = 2'd3;
      default:        c = 2'd1;
    endcase
    return c;
  endfunction

  function automatic logic [TAIL_W-1:0] tail_of(input opk_e k);
    logic [TAIL_W-1:0] t;
    case (k)
      K_IMM8, K_STK: t = 2'd1;
      K_IMM16:       t = 2'd2;
      default:       t = 2'd0;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/fseq_decode.sv
module fseq_decode import fseq_pkg::*; (
  input  logic [BYTE_W-1:0] op,
  output opk_e              kind,
  output logic [TAIL_W-1:0] tail
);
  always_comb begin
    kind = opk_of(op);
    tail = tail_of(kind);
  end
endmodule

// File: rtl/fseq_imm.sv
module fseq_imm import fseq_pkg::*; #(
  parameter int IMM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [IMM_W-1:0]  imm_next
);
  localparam int KEEP_W = IMM_W - BYTE_W;

  logic [IMM_W-1:0] imm_q;

  always_comb begin
    if (clr)
      imm_next = '0;
    else if (shift)
      imm_next = {imm_q[KEEP_W-1:0], byte_in};
    else
      imm_next = imm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) imm_q <= '0;
    else        imm_q <= imm_next;
  end

  // R4: the newest byte always lands in the low byte, pushing older ones up
  p_be_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr) |=> (imm_q[BYTE_W-1:0] == $past(byte_in)));
  // R5: a new opcode starts with an empty operand
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (imm_q == '0));
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl import fseq_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ready,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] stack_ptr,
  input  logic              slot_free,
  input  opk_e              dec_kind,
  input  logic [TAIL_W-1:0] dec_tail,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cap_op,
  output logic              cap_byte,
  output logic              load_rec,
  output logic [BYTE_W-1:0] rec_opcode,
  output opk_e              rec_kind,
  output logic [BYTE_W-1:0] rec_data,
  output logic [ADDR_W-1:0] rec_daddr
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [TAIL_W-1:0] TAIL_ONE = TAIL_W'(1);

  typedef enum logic [1:0] {ST_OP, ST_IMM, ST_DAT} st_e;

  st_e               st_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] daddr_q;
  logic [TAIL_W-1:0] rem_q;
  logic [BYTE_W-1:0] op_q;
  opk_e              kind_q;
  logic              fire;
  logic              last_imm;
  logic              dat_done;

  always_comb begin
    mem_rd_valid = (st_q == ST_OP) ? slot_free : 1'b1;
    mem_addr     = (st_q == ST_DAT) ? daddr_q : pc_q;
    fire         = mem_rd_valid && mem_ready;
    cap_op       = fire && (st_q == ST_OP);
    cap_byte     = fire && (st_q == ST_IMM);
    dat_done     = fire && (st_q == ST_DAT);
    last_imm     = cap_byte && (rem_q == TAIL_ONE);
    load_rec     = (cap_op && (dec_tail == '0))
                 || (last_imm && (kind_q != K_STK))
                 || dat_done;
    rec_opcode   = (st_q == ST_OP) ? mem_rdata : op_q;
    rec_kind     = (st_q == ST_OP) ? dec_kind : kind_q;
    rec_data     = (st_q == ST_DAT) ? mem_rdata : '0;
    rec_daddr    = (st_q == ST_DAT) ? daddr_q : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_OP;
      pc_q    <= '0;
      daddr_q <= '0;
      rem_q   <= '0;
      op_q    <= '0;
      kind_q  <= K_NONE;
    end else begin
      if (cap_op) begin
        op_q   <= mem_rdata;
        kind_q <= dec_kind;
        rem_q  <= dec_tail;
        pc_q   <= (dec_kind == K_RST) ? '0 : pc_q + ADDR_ONE;
        if (dec_tail != '0) st_q <= ST_IMM;
      end
      if (cap_byte) begin
        pc_q  <= pc_q + ADDR_ONE;
        rem_q <= rem_q - TAIL_ONE;
        if (rem_q == TAIL_ONE) begin
          if (kind_q == K_STK) begin
            st_q    <= ST_DAT;
            daddr_q <= stack_ptr + ADDR_W'(mem_rdata);
          end else begin
            st_q <= ST_OP;
          end
        end
      end
      if (dat_done) st_q <= ST_OP;
    end
  end

  // R9: a refused read keeps its request and address
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_ready) |=> (mem_rd_valid && $stable(mem_addr)));
  // R2: each consumed operand byte moves the read pointer by one
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_byte |=> (pc_q == $past(pc_q) + ADDR_ONE));
  // R7: the clear opcode sends fetching back to address zero
  p_clear_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_op && dec_kind == K_RST) |=> (pc_q == '0 && st_q == ST_OP));
  // R6: the data read follows straight after the offset byte
  p_stk_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_imm && kind_q == K_STK) |=> (st_q == ST_DAT && mem_rd_valid));
endmodule

// File: rtl/fseq_outreg.sv
module fseq_outreg import fseq_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] rec_opcode,
  input  opk_e              rec_kind,
  input  logic [IMM_W-1:0]  rec_imm,
  input  logic [BYTE_W-1:0] rec_data,
  input  logic [ADDR_W-1:0] rec_daddr,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_opcode,
  output opk_e              out_kind,
  output logic [IMM_W-1:0]  out_imm,
  output logic [CYC_W-1:0]  out_cycles,
  output logic [ADDR_W-1:0] out_daddr,
  output logic [BYTE_W-1:0] out_data,
  output logic              ill_q,
  output logic              clr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_opcode <= '0;
      out_kind   <= K_NONE;
      out_imm    <= '0;
      out_cycles <= '0;
      out_daddr  <= '0;
      out_data   <= '0;
      ill_q      <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      ill_q <= load && (rec_kind == K_ILL);
      clr_q <= load && (rec_kind == K_RST);
      if (load) begin
        out_valid  <= 1'b1;
        out_opcode <= rec_opcode;
        out_kind   <= rec_kind;
        out_imm    <= rec_imm;
        out_cycles <= cyc_of(rec_kind);
        out_daddr  <= rec_daddr;
        out_data   <= rec_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R10: a held record is never overwritten
  p_no_clobber_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !load);
  // R10: a refused record stays unchanged
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode)
      && $stable(out_imm) && $stable(out_kind) && $stable(out_daddr)
      && $stable(out_data)));
  // R7 R8: pulses last one cycle
  p_pulse_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_q || clr_q) |=> !(ill_q || clr_q));
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq import fseq_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic [ADDR_W-1:0] stack_ptr,
  output logic              ins_valid,
  input  logic              ins_ready,
  output logic [7:0]        ins_opcode,
  output logic [2:0]        ins_kind,
  output logic [IMM_W-1:0]  ins_imm,
  output logic [1:0]        ins_cycles,
  output logic [ADDR_W-1:0] ins_daddr,
  output logic [7:0]        ins_data,
  output logic              illegal_pulse,
  output logic              clear_pulse
);
  opk_e              dec_kind;
  logic [TAIL_W-1:0] dec_tail;
  logic              slot_free;
  logic              cap_op;
  logic              cap_byte;
  logic              load_rec;
  logic [BYTE_W-1:0] rec_opcode;
  opk_e              rec_kind;
  logic [BYTE_W-1:0] rec_data;
  logic [ADDR_W-1:0] rec_daddr;
  logic [IMM_W-1:0]  imm_next;
  opk_e              out_kind;

  assign slot_free = !ins_valid || ins_ready;
  assign ins_kind  = out_kind;

  fseq_decode u_dec (
    .op   (mem_rdata),
    .kind (dec_kind),
    .tail (dec_tail)
  );

  fseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_ready    (mem_ready),
    .mem_rdata    (mem_rdata),
    .stack_ptr    (stack_ptr),
    .slot_free    (slot_free),
    .dec_kind     (dec_kind),
    .dec_tail     (dec_tail),
    .mem_rd_valid (mem_rd_valid),
    .mem_addr     (mem_addr),
    .cap_op       (cap_op),
    .cap_byte     (cap_byte),
    .load_rec     (load_rec),
    .rec_opcode   (rec_opcode),
    .rec_kind     (rec_kind),
    .rec_data     (rec_data),
    .rec_daddr    (rec_daddr)
  );

  fseq_imm #(.IMM_W(IMM_W)) u_imm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cap_op),
    .shift    (cap_byte),
    .byte_in  (mem_rdata),
    .imm_next (imm_next)
  );

  fseq_outreg #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_rec),
    .rec_opcode (rec_opcode),
    .rec_kind   (rec_kind),
    .rec_imm    (imm_next),
    .rec_data   (rec_data),
    .rec_daddr  (rec_daddr),
    .out_ready  (ins_ready),
    .out_valid  (ins_valid),
    .out_opcode (ins_opcode),
    .out_kind   (out_kind),
    .out_imm    (ins_imm),
    .out_cycles (ins_cycles),
    .out_daddr  (ins_daddr),
    .out_data   (ins_data),
    .ill_q      (illegal_pulse),
    .clr_q      (clear_pulse)
  );

  // R10: a held record blocks further reads
  p_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |-> !mem_rd_valid);
  // R8: the two pulses are exclusive
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_pulse, clear_pulse}));
  // R8: the unassigned-opcode pulse rides on its own record
  p_ill_rec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> (ins_valid && out_kind == K_ILL));
  // R7: the clear pulse rides on its own record
  p_clr_rec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |-> (ins_valid && out_kind == K_RST));
  // R1: right after reset, the port asks for address zero
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!ins_valid && mem_rd_valid && mem_addr == '0));
endmodule

// File: tb/sim_fetch_seq.sv
`timescale 1ns/1ps
module sim_fetch_seq;
  localparam int CLK_PER = 10;
  localparam int SAMPLE  = 4;
  localparam int LIMIT   = 20000;

  typedef struct {
    logic [7:0]  op;
    logic [2:0]  kind;
    logic [15:0] imm;
    logic [1:0]  cyc;
    logic [15:0] daddr;
    logic [7:0]  data;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_rd_valid;
  logic        mem_ready;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [15:0] stack_ptr;
  logic        ins_valid;
  logic        ins_ready;
  logic [7:0]  ins_opcode;
  logic [2:0]  ins_kind;
  logic [15:0] ins_imm;
  logic [1:0]  ins_cycles;
  logic [15:0] ins_daddr;
  logic [7:0]  ins_data;
  logic        illegal_pulse;
  logic        clear_pulse;

  logic [7:0]  mem [0:1023];
  exp_t        q[$];
  logic [15:0] aq[$];
  int          wp = 0;
  int          checks = 0;
  int          fails = 0;
  int          recs = 0;
  int          cyc = 0;
  int          last_acc = 0;
  int          ill_cnt = 0;
  int          clr_cnt = 0;
  bit          mon_on = 1'b0;
  bit          p_stall = 1'b0;
  bit          p_hold = 1'b0;
  logic [15:0] p_addr;
  logic [7:0]  p_op;
  logic [15:0] p_imm;

  always #(CLK_PER/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:0]];

  fetch_seq u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_rd_valid  (mem_rd_valid),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr),
    .mem_rdata     (mem_rdata),
    .stack_ptr     (stack_ptr),
    .ins_valid     (ins_valid),
    .ins_ready     (ins_ready),
    .ins_opcode    (ins_opcode),
    .ins_kind      (ins_kind),
    .ins_imm       (ins_imm),
    .ins_cycles    (ins_cycles),
    .ins_daddr     (ins_daddr),
    .ins_data      (ins_data),
    .illegal_pulse (illegal_pulse),
    .clear_pulse   (clear_pulse)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Driver: writes an instruction into memory and queues its expectations.
  task automatic put(input logic [7:0] op, input logic [2:0] k,
                     input logic [7:0] b1, input logic [7:0] b2,
                     input logic [15:0] da, input logic [7:0] db);
    exp_t e;
    int n;
    n = (k == 3'd2) ? 2 : ((k == 3'd1 || k == 3'd3) ? 1 : 0);
    mem[wp] = op;
    aq.push_back(16'(wp));
    if (n >= 1) begin mem[wp+1] = b1; aq.push_back(16'(wp+1)); end
    if (n == 2) begin mem[wp+2] = b2; aq.push_back(16'(wp+2)); end
    if (k == 3'd3) begin mem[da[9:0]] = db; aq.push_back(da); end
    e.op    = op;
    e.kind  = k;
    e.imm   = (k == 3'd2) ? {b1, b2} : ((n == 1) ? {8'h00, b1} : 16'h0000);
    e.cyc   = (k == 3'd1) ? 2'd2 : ((k == 3'd2 || k == 3'd3) ? 2'd3 : 2'd1);
    e.daddr = (k == 3'd3) ? da : 16'h0000;
    e.data  = (k == 3'd3) ? db : 8'h00;
    q.push_back(e);
    wp = (k == 3'd4) ? 0 : wp + 1 + n;
  endtask

  task automatic program_pass();
    put(8'hA2, 3'd0, 8'h00, 8'h00, 16'h0000, 8'h00);
    put(8'h24, 3'd1, 8'h5A, 8'h00, 16'h0000, 8'h00);
    put(8'h06, 3'd2, 8'h12, 8'h34, 16'h0000, 8'h00);
    put(8'hB0, 3'd3, 8'h40, 8'h00, 16'h0030, 8'h77);
    put(8'h70, 3'd5, 8'h00, 8'h00, 16'h0000, 8'h00);
    put(8'hD5, 3'd3, 8'h05, 8'h00, 16'hFFF5, 8'hAB);
    put(8'h7C, 3'd2, 8'hBE, 8'hEF, 16'h0000, 8'h00);
    put(8'h75, 3'd1, 8'h80, 8'h00, 16'h0000, 8'h00);
    put(8'h00, 3'd4, 8'h00, 8'h00, 16'h0000, 8'h00);
  endtask

  // Monitor: samples just before each rising edge.
  always begin
    @(negedge clk);
    #(SAMPLE);
    cyc++;
    if (mon_on) begin
      if (p_stall)
        chk(mem_rd_valid && mem_addr == p_addr, "R9 held request", {16'h0, mem_addr}, {16'h0, p_addr});
      if (p_hold) begin
        chk(ins_valid && ins_opcode == p_op, "R10 held opcode", {24'h0, ins_opcode}, {24'h0, p_op});
        chk(ins_imm == p_imm, "R10 held imm", {16'h0, ins_imm}, {16'h0, p_imm});
      end
      if (ins_valid && !ins_ready)
        chk(!mem_rd_valid, "R10 no read while held", {31'h0, mem_rd_valid}, 32'h0);
      if (mem_rd_valid && mem_ready) begin
        if (aq.size() == 0) begin
          chk(1'b0, "R2 unexpected read", {16'h0, mem_addr}, 32'hFFFFFFFF);
        end else begin
          logic [15:0] ea;
          ea = aq.pop_front();
          chk(mem_addr == ea, "R2 R6 R7 read address", {16'h0, mem_addr}, {16'h0, ea});
        end
      end
      if (illegal_pulse) begin
        ill_cnt++;
        chk(ins_valid && ins_kind == 3'd5, "R8 pulse alignment", {29'h0, ins_kind}, 32'd5);
      end
      if (clear_pulse) begin
        clr_cnt++;
        chk(ins_valid && ins_kind == 3'd4, "R7 pulse alignment", {29'h0, ins_kind}, 32'd4);
      end
      if (ins_valid && ins_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3 unexpected record", {24'h0, ins_opcode}, 32'hFFFFFFFF);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(ins_opcode == e.op, "R2 opcode", {24'h0, ins_opcode}, {24'h0, e.op});
          chk(ins_kind == e.kind, "R3 kind", {29'h0, ins_kind}, {29'h0, e.kind});
          chk(ins_imm == e.imm, "R4 R5 immediate", {16'h0, ins_imm}, {16'h0, e.imm});
          chk(ins_cycles == e.cyc, "R11 cycle count", {30'h0, ins_cycles}, {30'h0, e.cyc});
          chk(ins_daddr == e.daddr, "R6 data address", {16'h0, ins_daddr}, {16'h0, e.daddr});
          chk(ins_data == e.data, "R6 data byte", {24'h0, ins_data}, {24'h0, e.data});
          if (recs >= 1 && recs <= 8)
            chk((cyc - last_acc) == int'(e.cyc), "R11 record spacing",
                32'(cyc - last_acc), {30'h0, e.cyc});
          last_acc = cyc;
          recs++;
        end
      end
      p_stall = mem_rd_valid && !mem_ready;
      p_addr  = mem_addr;
      p_hold  = ins_valid && !ins_ready;
      p_op    = ins_opcode;
      p_imm   = ins_imm;
    end
  end

  initial begin
    logic [7:0] lfsr;
    bit timed_out;
    lfsr = 8'hA5;
    timed_out = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    for (int pass = 0; pass < 2; pass++) program_pass();
    aq.push_back(16'h0000);
    rst_n = 1'b0;
    ins_ready = 1'b0;
    mem_ready = 1'b0;
    stack_ptr = 16'hFFF0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ins_ready = 1'b1;
    mem_ready = 1'b1;
    #(SAMPLE - 1);
    // R1: reset state before the first active edge
    chk(!ins_valid, "R1 ins_valid", {31'h0, ins_valid}, 32'h0);
    chk(mem_rd_valid, "R1 mem_rd_valid", {31'h0, mem_rd_valid}, 32'h1);
    chk(mem_addr == 16'h0000, "R1 mem_addr", {16'h0, mem_addr}, 32'h0);
    mon_on = 1'b1;
    while (recs < 18) begin
      @(negedge clk);
      if (cyc > LIMIT) begin
        timed_out = 1'b1;
        break;
      end
      if (recs >= 9) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = lfsr[0] | lfsr[3];
        ins_ready = lfsr[1] | lfsr[6];
      end
    end
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, LIMIT);
    end else begin
      ins_ready = 1'b0;
      mem_ready = 1'b1;
      repeat (10) @(negedge clk);
      #(SAMPLE + 1);
      chk(aq.size() == 0, "R2 all reads seen", 32'(aq.size()), 32'h0);
      chk(q.size() == 0, "R3 all records seen", 32'(q.size()), 32'h0);
      chk(ill_cnt == 2, "R8 pulse count", 32'(ill_cnt), 32'd2);
      chk(clr_cnt == 2, "R7 pulse count", 32'(clr_cnt), 32'd2);
      chk(ins_valid && ins_opcode == 8'hA2, "R10 parked record", {24'h0, ins_opcode}, 32'hA2);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule